// File: doc/BRIEF.md
# Conditional Erase-Write Cell Controller

This block accepts single-byte write requests and turns each into the smallest set of commands that a byte-wide non-volatile cell array needs. The array has two independent commands. An erase command forces every bit of a cell to one. A program command can only pull bits to zero, so the cell ends up holding the old contents ANDed with the programmed data. For every request the controller first reads the stored byte. It then compares that byte with the requested value and takes one of four routes: do nothing, program only, erase then program, or erase only.

Requests arrive on a valid/ready channel. The requester raises `req_valid` with the address and data and holds all three steady until it sees `req_ready` high at a clock edge. `req_ready` is high only while the controller is idle, so it applies back-pressure for the whole of a request, from the read to the final `done` pulse. The cell array sees a one-cycle-latency read port and single-cycle erase and program strobes. All three share one address output. After each strobe the controller waits a fixed, parameterized number of cycles. Two saturating counters report how many erases and programs have been issued.

Top module: `cond_write_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1. `busy`, `done`, `rd_en`, `erase_stb` and `prog_stb` are 0, and both counters are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `busy` is 1 and `req_ready` is 0 until the cycle after `done`.
- R3: Each accepted request causes exactly one `rd_en` cycle, with `cell_addr` equal to the request address. `rd_data` is sampled one cycle later.
- R4: If the stored byte equals the requested byte, no erase and no program is issued, and `busy` lasts 3 cycles.
- R5: If the bytes differ and (stored AND new) equals new, one program is issued with `prog_data` equal to the new byte, and no erase is issued.
- R6: If (stored AND new) differs from new and new is not 0xFF, one erase is issued, then one program of the new byte, at the request address.
- R7: If the bytes differ and new is 0xFF, one erase is issued and no program.
- R8: After an erase strobe the controller stays busy for exactly ERASE_WAIT further cycles before its next step. After a program strobe it waits PROG_WAIT cycles. `busy` therefore lasts 3 + (ERASE_WAIT+1 if erased) + (PROG_WAIT+1 if programmed) cycles.
- R9: `done` is high for exactly one cycle per request, on every route including the do-nothing route.
- R10: `erase_count` and `prog_count` go up by one for each erase or program strobe. Each stops at 2^CNT_W-1.
- R11: `erase_stb` and `prog_stb` are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Cell address of the request |
| req_data | input | DATA_W | Byte to store |
| rd_en | output | 1 | Read the cell at `cell_addr`; data returns next cycle |
| cell_addr | output | ADDR_W | Address for read, erase and program |
| rd_data | input | DATA_W | Stored byte returned by the array |
| erase_stb | output | 1 | Erase the cell at `cell_addr` to all ones |
| prog_stb | output | 1 | AND `prog_data` into the cell at `cell_addr` |
| prog_data | output | DATA_W | Data for a program strobe |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| erase_count | output | CNT_W | Saturating count of erases issued |
| prog_count | output | CNT_W | Saturating count of programs issued |

## Verification
The bench drives writes into a cell model and focuses on the route boundaries. Cases include rewriting an identical byte, where a design that skips the compare would issue a wasted program, and a new value that only clears bits, where a sloppy test would erase needlessly. Writing 0xFF over a partly cleared cell must erase but not program; a design that always programs after an erase shows an extra program count. Busy length per route exposes off-by-one wait timers. A long run of alternating 0x00/0xFF writes drives both counters past their limit, where a wrapping counter would read a small value instead of the maximum.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CMP,
    ST_ERS,
    ST_EWAIT,
    ST_PRG,
    ST_PWAIT,
    ST_FIN
  } cwc_state_t;

  typedef enum logic [1:0] {
    RT_SKIP,
    RT_PROG,
    RT_ERASE,
    RT_ERASE_PROG
  } cwc_route_t;

endpackage

// File: rtl/cwc_route_sel.sv
module cwc_route_sel
  import cwc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] wanted,
  output cwc_route_t        route
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic differs;
  logic must_erase;
  logic wants_ones;

  always_comb begin
    differs    = (stored != wanted);
    must_erase = ((stored & wanted) != wanted);
    wants_ones = (wanted == ALL_ONES);
    if (!differs)        route = RT_SKIP;
    else if (!must_erase) route = RT_PROG;
    else if (wants_ones)  route = RT_ERASE;
    else                  route = RT_ERASE_PROG;
  end
endmodule

// File: rtl/cwc_wait_timer.sv
module cwc_wait_timer #(
  parameter int MAX_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic [$clog2(MAX_WAIT+1)-1:0] load_val,
  output logic expired
);
  localparam int TW = $clog2(MAX_WAIT+1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain <= '0;
    else if (load)             remain <= load_val;
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);

  // R8
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));

  // R8
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= TW'(MAX_WAIT));
endmodule

// File: rtl/cwc_sat_counter.sv
module cwc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   value <= '0;
    else if (bump && value != TOP) value <= value + 1'b1;
  end

  // R10
  cnt_hold_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (value == TOP) |=> (value == TOP));

  // R10
  cnt_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(value));
endmodule

// File: rtl/cond_write_ctrl.sv
module cond_write_ctrl
  import cwc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int ERASE_WAIT = 4,
  parameter int PROG_WAIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] cell_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              erase_stb,
  output logic              prog_stb,
  output logic [DATA_W-1:0] prog_data,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  erase_count,
  output logic [CNT_W-1:0]  prog_count
);
  localparam int MAX_WAIT = (ERASE_WAIT > PROG_WAIT) ? ERASE_WAIT : PROG_WAIT;
  localparam int TW       = $clog2(MAX_WAIT+1);
  localparam int N_CNT    = 2;

  cwc_state_t        state, state_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              prog_after_q;
  cwc_route_t        route;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_done;
  logic              take;

  assign take = req_valid && (state == ST_IDLE);

  cwc_route_sel #(.DATA_W(DATA_W)) u_route (
    .stored (rd_data),
    .wanted (data_q),
    .route  (route)
  );

  cwc_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE:  if (take) state_nx = ST_READ;
      ST_READ:  state_nx = ST_CMP;
      ST_CMP: begin
        unique case (route)
          RT_SKIP:  state_nx = ST_FIN;
          RT_PROG:  state_nx = ST_PRG;
          default:  state_nx = ST_ERS;
        endcase
      end
      ST_ERS: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(ERASE_WAIT - 1);
        state_nx = ST_EWAIT;
      end
      ST_EWAIT: if (tmr_done) state_nx = prog_after_q ? ST_PRG : ST_FIN;
      ST_PRG: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(PROG_WAIT - 1);
        state_nx = ST_PWAIT;
      end
      ST_PWAIT: if (tmr_done) state_nx = ST_FIN;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      addr_q       <= '0;
      data_q       <= '0;
      prog_after_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
      if (state == ST_CMP) prog_after_q <= (route == RT_ERASE_PROG);
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rd_en     = (state == ST_READ);
  assign erase_stb = (state == ST_ERS);
  assign prog_stb  = (state == ST_PRG);
  assign done      = (state == ST_FIN);
  assign cell_addr = addr_q;
  assign prog_data = data_q;

  logic [N_CNT-1:0]            cnt_bump;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_val;

  assign cnt_bump = {prog_stb, erase_stb};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    cwc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (cnt_bump[g]),
      .value (cnt_val[g])
    );
  end

  assign erase_count = cnt_val[0];
  assign prog_count  = cnt_val[1];

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_stb && prog_stb));

  // R11
  erase_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |=> !erase_stb);

  // R11
  prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_stb |=> !prog_stb);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  // R3
  read_then_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (!rd_en && busy && $stable(cell_addr)));
endmodule

// File: tb/cond_write_ctrl_bench.sv
module cond_write_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int EW = 3;
  localparam int PW = 2;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic rd_en, erase_stb, prog_stb, busy, done;
  logic [AW-1:0] cell_addr;
  logic [DW-1:0] rd_data, prog_data;
  logic [CW-1:0] erase_count, prog_count;

  always #10 clk = ~clk;

  cond_write_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .ERASE_WAIT(EW), .PROG_WAIT(PW)
  ) u_cond_write_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en),
    .cell_addr(cell_addr), .rd_data(rd_data), .erase_stb(erase_stb),
    .prog_stb(prog_stb), .prog_data(prog_data), .busy(busy), .done(done),
    .erase_count(erase_count), .prog_count(prog_count)
  );

  // cell array model: erase -> all ones, program -> AND
  logic [DW-1:0] mem [1<<AW];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '1;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= mem[cell_addr];
      if (erase_stb) mem[cell_addr] <= '1;
      if (prog_stb)  mem[cell_addr] <= mem[cell_addr] & prog_data;
    end
  end

  int er_tot = 0, pg_tot = 0, rd_tot = 0, busy_tot = 0, done_tot = 0, rd_bad = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (erase_stb) er_tot++;
      if (prog_stb)  pg_tot++;
      if (rd_en) begin
        rd_tot++;
        if (cell_addr != req_addr) rd_bad++;
      end
      if (busy) busy_tot++;
      if (done) done_tot++;
    end
  end

  int n_run = 0, n_fail = 0;
  int exp_er = 0, exp_pg = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {addr, data, expect_erase, expect_prog}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {4'd0, 8'hA5, 1'b0, 1'b1},  // R5 program from blank
    {4'd0, 8'hA5, 1'b0, 1'b0},  // R4 identical
    {4'd0, 8'h81, 1'b0, 1'b1},  // R5 clear bits only
    {4'd0, 8'hC3, 1'b1, 1'b1},  // R6 needs a raised bit
    {4'd0, 8'hFF, 1'b1, 1'b0},  // R7 erase only
    {4'd1, 8'h00, 1'b0, 1'b1},  // R5
    {4'd1, 8'hFF, 1'b1, 1'b0},  // R7
    {4'd2, 8'hFF, 1'b0, 1'b0},  // R4 blank over blank
    {4'd3, 8'h0F, 1'b0, 1'b1},  // R5
    {4'd3, 8'hF0, 1'b1, 1'b1},  // R6
    {4'd3, 8'h00, 1'b0, 1'b1},  // R5
    {4'd3, 8'h00, 1'b0, 1'b0}   // R4
  };

  task automatic do_req(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit xe, input bit xp);
    int e0, p0, r0, b0, d0, guard, exp_busy;
    e0 = er_tot; p0 = pg_tot; r0 = rd_tot; b0 = busy_tot; d0 = done_tot;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0 && busy == 1'b1, "R2 back-pressure while busy", req_ready, 0);
    guard = 0;
    while (done_tot == d0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 200, "R9 done reached", guard, 0);
    if (xe) exp_er = (exp_er < int'(CMAX)) ? exp_er + 1 : exp_er;
    if (xp) exp_pg = (exp_pg < int'(CMAX)) ? exp_pg + 1 : exp_pg;
    exp_busy = 3 + (xe ? EW + 1 : 0) + (xp ? PW + 1 : 0);
    check(er_tot - e0 == int'(xe), "R6/R7 erase strobes", er_tot - e0, int'(xe));
    check(pg_tot - p0 == int'(xp), "R4/R5 program strobes", pg_tot - p0, int'(xp));
    check(rd_tot - r0 == 1, "R3 one read", rd_tot - r0, 1);
    check(busy_tot - b0 == exp_busy, "R8 busy length", busy_tot - b0, exp_busy);
    check(done_tot - d0 == 1 && !done, "R9 single done", done_tot - d0, 1);
    check(mem[a] == d, "R6 stored value", int'(mem[a]), int'(d));
    check(int'(erase_count) == exp_er, "R10 erase_count", int'(erase_count), exp_er);
    check(int'(prog_count) == exp_pg, "R10 prog_count", int'(prog_count), exp_pg);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    check(req_ready && !busy && !done && !rd_en && !erase_stb && !prog_stb,
          "R1 outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !done, "R1 idle after reset", int'(busy), 0);
    check(erase_count == '0 && prog_count == '0, "R1 counters zero",
          int'(erase_count) + int'(prog_count), 0);

    for (int i = 0; i < NV; i++)
      do_req(VEC[i][13:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);

    // R10 saturation: each pair adds one program and one erase
    for (int i = 0; i < 12; i++) begin
      do_req(4'd4, 8'h00, 1'b0, 1'b1);
      do_req(4'd4, 8'hFF, 1'b1, 1'b0);
    end
    check(erase_count == CMAX, "R10 erase saturates", int'(erase_count), int'(CMAX));
    check(prog_count == CMAX, "R10 prog saturates", int'(prog_count), int'(CMAX));
    check(rd_bad == 0, "R3 read address", rd_bad, 0);

    // R1 reset mid-life clears counters
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(erase_count == '0 && prog_count == '0 && req_ready, "R1 counters after reset",
          int'(erase_count), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule